// File: doc/BRIEF.md
# Slack-Buffered Link Receiver with Backward Stop/Go Flow Control

This block terminates the receive half of a full-duplex byte link whose characters are nine bits wide: the top bit marks a control symbol and the low eight bits carry either a data byte or a control code. Incoming data bytes land in an 80-byte slack FIFO that downstream logic drains through a valid/ready byte stream. Control characters never enter the FIFO.

The block watches the FIFO fill level and sends flow-control symbols back to the far sender on the reverse channel. When occupancy climbs to 48 bytes it sends a stop symbol. The 32 free bytes above that point absorb the characters already on the wire. When occupancy drains to 32 bytes it sends a go symbol. The 32 bytes still queued keep the output busy while the go travels back. Between the two points lies a 16-byte hysteresis band. Each symbol goes out once per crossing, and a pending symbol is given priority over local data on the reverse channel. Stop and go symbols that arrive from the far end are decoded into a transmit-enable for the local sender.

Top module: `slack_rx_flow`

## Requirements
- R1: While reset is held, and after it is released, out_vld, ovf_err and peer_tx_en are 0. The reverse channel carries a go symbol ({1, 8'hC3}) on the first clock edge after reset release.
- R2: Data characters (bit 8 = 0) are stored and delivered on out_data in arrival order. out_vld is high whenever the FIFO holds a byte, and one byte is removed on each cycle with out_vld and out_rdy both high. The FIFO holds up to 80 bytes.
- R3: Received control characters (bit 8 = 1) never enter the FIFO.
- R4: When the registered occupancy is at or above 48 and the last symbol sent was go, a stop symbol ({1, 8'h3C}) is queued. No further stop is queued until a go has been queued.
- R5: When the registered occupancy is at or below 32 and the last symbol sent was stop, a go symbol is queued. No further go is queued until a stop has been queued.
- R6: A queued symbol goes out on the next reverse slot ahead of local data. tx_data_rdy is low while a symbol is queued, so at most one data character goes out between the threshold cycle and the symbol.
- R7: A data character that arrives while the FIFO holds 80 bytes is dropped, and ovf_err rises and stays high until reset.
- R8: A received {1, 8'h3C} clears peer_tx_en and a received {1, 8'hC3} sets it. Other control codes leave it unchanged.
- R9: Reverse characters are registered. Local data goes out as {0, byte} one cycle after it is accepted with tx_data_vld and tx_data_rdy. A cycle with nothing to send drives rev_vld low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_vld | input | 1 | Inbound link character valid |
| rx_char | input | 9 | Inbound character, bit 8 marks a control symbol |
| out_vld | output | 1 | FIFO output byte valid |
| out_data | output | 8 | FIFO output byte |
| out_rdy | input | 1 | Downstream accepts the output byte |
| tx_data_vld | input | 1 | Local sender has a data byte for the reverse channel |
| tx_data | input | 8 | Local data byte |
| tx_data_rdy | output | 1 | Reverse channel takes the local byte this cycle |
| rev_vld | output | 1 | Reverse-channel character valid |
| rev_char | output | 9 | Reverse-channel character |
| peer_tx_en | output | 1 | Far end permits local transmission |
| ovf_err | output | 1 | Sticky overflow flag |

## Verification
The embedded assertions check several rules on every cycle: the occupancy bound, that control characters leave the occupancy unchanged, that a full FIFO with data arriving raises the sticky error, that a threshold crossing is followed by exactly the right symbol on the next reverse slot, that accepted local data appears on the next cycle, and that received stop/go codes update the transmit-enable. Other behaviours only show up in the bench's scenarios, where a cycle-level reference model is compared against the ports. These are byte ordering across wrap-around, the single stop per fill and single go per drain with hysteresis under bursty draining, and overflow under a stalled consumer.

// File: rtl/slack_rx_flow.sv
module slack_rx_flow #(
  parameter int          LO_SLACK = 32,
  parameter int          HYST     = 16,
  parameter int          HI_SLACK = 32,
  parameter logic [7:0]  SYM_STOP = 8'h3C,
  parameter logic [7:0]  SYM_GO   = 8'hC3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rx_vld,
  input  logic [8:0] rx_char,
  output logic       out_vld,
  output logic [7:0] out_data,
  input  logic       out_rdy,
  input  logic       tx_data_vld,
  input  logic [7:0] tx_data,
  output logic       tx_data_rdy,
  output logic       rev_vld,
  output logic [8:0] rev_char,
  output logic       peer_tx_en,
  output logic       ovf_err
);
  localparam int DEPTH = LO_SLACK + HYST + HI_SLACK;
  localparam int PW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [CW-1:0] FULL_LVL = CW'(DEPTH);
  localparam logic [CW-1:0] STOP_LVL = CW'(LO_SLACK + HYST);
  localparam logic [CW-1:0] GO_LVL   = CW'(LO_SLACK);
  localparam logic [PW-1:0] LAST_IDX = PW'(DEPTH - 1);

  logic [7:0]    mem [DEPTH];
  logic [PW-1:0] wp, rp;
  logic [CW-1:0] cnt;
  logic          stopped, pend_vld, pend_stop;

  wire in_data = rx_vld & ~rx_char[8];
  wire in_ctrl = rx_vld &  rx_char[8];
  wire full    = (cnt == FULL_LVL);
  wire wr      = in_data & ~full;
  wire rd      = out_vld & out_rdy;
  wire stop_ev = ~stopped & (cnt >= STOP_LVL);
  wire go_ev   =  stopped & (cnt <= GO_LVL);

  assign out_vld     = (cnt != '0);
  assign out_data    = mem[rp];
  assign tx_data_rdy = ~pend_vld;

  always_ff @(posedge clk) begin
    if (wr) mem[wp] <= rx_char[7:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp <= '0;
      rp <= '0;
      cnt <= '0;
    end else begin
      if (wr) wp <= (wp == LAST_IDX) ? '0 : wp + 1'b1;
      if (rd) rp <= (rp == LAST_IDX) ? '0 : rp + 1'b1;
      if (wr && !rd)      cnt <= cnt + 1'b1;
      else if (!wr && rd) cnt <= cnt - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stopped   <= 1'b0;
      pend_vld  <= 1'b1;
      pend_stop <= 1'b0;
    end else if (stop_ev || go_ev) begin
      stopped   <= stop_ev;
      pend_vld  <= 1'b1;
      pend_stop <= stop_ev;
    end else if (pend_vld) begin
      pend_vld  <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rev_vld  <= 1'b0;
      rev_char <= '0;
    end else if (pend_vld) begin
      rev_vld  <= 1'b1;
      rev_char <= {1'b1, pend_stop ? SYM_STOP : SYM_GO};
    end else if (tx_data_vld) begin
      rev_vld  <= 1'b1;
      rev_char <= {1'b0, tx_data};
    end else begin
      rev_vld  <= 1'b0;
      rev_char <= '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      peer_tx_en <= 1'b0;
      ovf_err    <= 1'b0;
    end else begin
      if (in_ctrl && rx_char[7:0] == SYM_STOP)    peer_tx_en <= 1'b0;
      else if (in_ctrl && rx_char[7:0] == SYM_GO) peer_tx_en <= 1'b1;
      if (in_data && full) ovf_err <= 1'b1;
    end
  end

  p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= FULL_LVL);
  p_ctrl_not_stored_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ctrl && !rd) |=> $stable(cnt));
  p_stop_sent_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stopped) |=> (rev_vld && rev_char == {1'b1, SYM_STOP}));
  p_go_sent_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(stopped) |=> (rev_vld && rev_char == {1'b1, SYM_GO}));
  p_data_fwd_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_data_vld && tx_data_rdy) |=> (rev_vld && !rev_char[8]));
  p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_data && full) |=> ovf_err);
  p_ovf_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_err |=> ovf_err);
  p_peer_stop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ctrl && rx_char[7:0] == SYM_STOP) |=> !peer_tx_en);
  p_peer_go_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ctrl && rx_char[7:0] == SYM_GO) |=> peer_tx_en);
endmodule

// File: tb/slack_rx_flow_tb_top.sv
module slack_rx_flow_tb_top;
  localparam int DEPTH = 80;
  localparam int STOP_LVL = 48;
  localparam int GO_LVL = 32;
  localparam logic [7:0] C_STOP = 8'h3C;
  localparam logic [7:0] C_GO = 8'hC3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic rx_vld = 1'b0, out_rdy = 1'b0, tx_data_vld = 1'b0;
  logic [8:0] rx_char = '0;
  logic [7:0] tx_data = '0;
  logic out_vld, tx_data_rdy, rev_vld, peer_tx_en, ovf_err;
  logic [7:0] out_data;
  logic [8:0] rev_char;

  int n_chk = 0, n_err = 0, n_stop_seen = 0, n_go_seen = 0;
  bit done = 1'b0;

  logic [7:0] mq[$];
  bit m_stopped, m_pend, m_pstop, m_rev_vld, m_peer, m_ovf;
  logic [8:0] m_rev;

  always #4 clk = ~clk;

  slack_rx_flow dut_i (
    .clk(clk), .rst_n(rst_n), .rx_vld(rx_vld), .rx_char(rx_char),
    .out_vld(out_vld), .out_data(out_data), .out_rdy(out_rdy),
    .tx_data_vld(tx_data_vld), .tx_data(tx_data), .tx_data_rdy(tx_data_rdy),
    .rev_vld(rev_vld), .rev_char(rev_char), .peer_tx_en(peer_tx_en), .ovf_err(ovf_err));

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic bit exp_out_vld();
    return mq.size() != 0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      mq.delete();
      m_stopped = 0; m_pend = 1; m_pstop = 0;
      m_rev_vld = 0; m_rev = '0; m_peer = 0; m_ovf = 0;
    end else begin
      int occ;
      bit rd, dat, sev, gev;
      occ = mq.size();
      rd  = exp_out_vld() && out_rdy;
      dat = rx_vld && !rx_char[8];
      sev = !m_stopped && occ >= STOP_LVL;
      gev = m_stopped && occ <= GO_LVL;
      if (m_pend) begin
        m_rev_vld = 1; m_rev = {1'b1, m_pstop ? C_STOP : C_GO};
      end else if (tx_data_vld) begin
        m_rev_vld = 1; m_rev = {1'b0, tx_data};
      end else m_rev_vld = 0;
      if (sev || gev) begin
        m_stopped = sev; m_pend = 1; m_pstop = sev;
      end else m_pend = 0;
      if (dat && occ == DEPTH) m_ovf = 1;
      if (rd) void'(mq.pop_front());
      if (dat && occ < DEPTH) mq.push_back(rx_char[7:0]);
      if (rx_vld && rx_char[8] && rx_char[7:0] == C_STOP) m_peer = 0;
      else if (rx_vld && rx_char[8] && rx_char[7:0] == C_GO) m_peer = 1;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R2", "out_vld", out_vld, exp_out_vld());
      if (exp_out_vld()) chk("R2", "out_data", out_data, mq[0]);
      chk("R6", "tx_data_rdy", tx_data_rdy, !m_pend);
      chk("R9", "rev_vld", rev_vld, m_rev_vld);
      if (m_rev_vld) chk("R9", "rev_char", rev_char, m_rev);
      chk("R8", "peer_tx_en", peer_tx_en, m_peer);
      chk("R7", "ovf_err", ovf_err, m_ovf);
      if (rev_vld && rev_char == {1'b1, C_STOP}) n_stop_seen++;
      if (rev_vld && rev_char == {1'b1, C_GO}) n_go_seen++;
    end
  end

  task automatic cyc(input bit rv, input logic [8:0] rc, input bit ordy, input bit tv, input logic [7:0] td);
    rx_vld = rv; rx_char = rc; out_rdy = ordy; tx_data_vld = tv; tx_data = td;
    @(negedge clk);
  endtask

  initial begin
    int base;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    chk("R1", "out_vld in reset", out_vld, 0);
    chk("R1", "ovf_err in reset", ovf_err, 0);
    chk("R1", "peer_tx_en in reset", peer_tx_en, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "first rev is go", rev_char, {1'b1, C_GO});
    chk("R1", "first rev valid", rev_vld, 1);
    n_go_seen = 0;
    for (int i = 0; i < 90; i++) cyc(1, {1'b0, 8'(i)}, 0, 1, 8'(8'hA0 + i));
    cyc(0, '0, 0, 0, '0);
    chk("R4", "single stop during fill", n_stop_seen, 1);
    chk("R7", "overflow raised", ovf_err, 1);
    chk("R2", "head byte after fill", out_data, 0);
    base = n_go_seen;
    for (int i = 0; i < 100; i++) cyc(0, '0, 1, 0, '0);
    chk("R5", "single go during drain", n_go_seen - base, 1);
    chk("R2", "empty after drain", out_vld, 0);
    cyc(1, {1'b1, C_GO}, 0, 0, '0);
    cyc(1, {1'b1, 8'h55}, 0, 0, '0);
    chk("R3", "control chars not stored", out_vld, 0);
    chk("R8", "peer enabled by go", peer_tx_en, 1);
    cyc(1, {1'b1, C_STOP}, 0, 0, '0);
    chk("R8", "peer disabled by stop", peer_tx_en, 0);
    for (int i = 0; i < 6000; i++) begin
      int ph = (i / 500) % 3;
      int r = $urandom_range(99);
      bit rv = (r < (ph == 0 ? 90 : 50));
      bit ctl = ($urandom_range(15) == 0);
      logic [7:0] b = 8'($urandom);
      if (ctl) b = ($urandom_range(2) == 0) ? C_STOP : (($urandom_range(1) == 0) ? C_GO : b);
      cyc(rv, {ctl, b}, $urandom_range(99) < (ph == 1 ? 90 : 45),
          $urandom_range(1) == 1, 8'($urandom));
    end
    for (int i = 0; i < 100; i++) cyc(0, '0, 1, 0, '0);
    chk("R2", "drained at end", out_vld, 0);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    #(8 * 150000);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule